// File: doc/BRIEF.md
# Paged Address Translator with Table Walk

This block turns virtual addresses into physical addresses for a single-level paged memory. The high bits of each virtual address name a page. The low bits are an offset within that page and pass through unchanged. A small fully associative cache of recent mappings is searched for the page. On a match, the physical address is formed from the cached frame and the offset in the same cycle the request is accepted.

When no cached mapping matches, the block stalls new requests. It issues a single read to a page table in memory, at the table's base address plus the page number. Each table entry holds a presence bit above a frame number. If the presence bit is set, the response completes with the new physical address and the mapping is written into the cache. If the bit is clear, the response reports a fault and the cache is left untouched.

Software can lock mappings into chosen cache slots. Locked slots are never chosen as refill victims and survive a flush. A single-cycle flush drops every unlocked mapping. Two counters record accepted hits and accepted misses.

Top module: `vat_translator`

## Requirements
- R1: The page number is req_vaddr[VA_W-1:OFF_W] and the offset is req_vaddr[OFF_W-1:0]. A request to a cached page is answered in its acceptance cycle with rsp_valid=1, rsp_hit=1 and rsp_paddr={frame, offset}. No memory read is made for it.
- R2: A request that misses causes exactly one read, with mem_rd_en high for a single cycle and mem_rd_addr = pt_base + page number. req_ready stays low from acceptance until the response.
- R3: A table entry is {present bit at bit PFN_W, frame in bits PFN_W-1:0}. When the entry is present, the response gives rsp_hit=0, rsp_fault=0 and rsp_paddr={frame, offset}. The mapping is then cached, so a later request to that page hits.
- R4: When the entry's present bit is 0, the response gives rsp_fault=1. Nothing is cached, so a repeat request walks again and faults again.
- R5: A refill writes the slot chosen by a round-robin pointer that starts at slot 0 after reset. The search goes upward from the pointer and wraps. After each refill, the pointer moves to the slot after the one written.
- R6: A locked slot is never chosen for refill. The pointer search steps over it, and its mapping keeps hitting across any number of refills.
- R7: When every slot is locked, a miss whose entry is present still completes with the correct address. The refill is dropped, so the next request to that page misses again.
- R8: A one-cycle pulse on flush removes every unlocked mapping and keeps every locked one.
- R9: A wire_en pulse writes wire_vpn and wire_pfn into slot wire_slot as a locked, valid mapping. Requests to that page then hit with that frame, whatever the page table holds for it.
- R10: hit_count and miss_count start at 0 and each rises by one for every accepted request that hits or misses, respectively.
- R11: During and after reset, req_ready=1, rsp_valid=0 and mem_rd_en=0, and the cache holds no mappings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | VA_W | Virtual address |
| req_ready | output | 1 | Block can accept a request (low during a walk) |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_fault | output | 1 | Page not present in the table |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address |
| pt_base | input | AW | Page-table base address |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | AW | Table entry address |
| mem_rd_valid | input | 1 | Table read data present |
| mem_rd_data | input | PFN_W+1 | Table entry {present, frame} |
| flush | input | 1 | Drop all unlocked mappings |
| wire_en | input | 1 | Write a locked mapping |
| wire_slot | input | log2(TLB_N) | Slot to lock |
| wire_vpn | input | VA_W-OFF_W | Page of the locked mapping |
| wire_pfn | input | PFN_W | Frame of the locked mapping |
| hit_count | output | CNT_W | Accepted hits |
| miss_count | output | CNT_W | Accepted misses |

## Verification
The bench builds the block with a 14-bit virtual space and 2 KB pages (OFF_W=11), which gives eight pages. It uses four cache slots and 4-bit frames. A table at base 0x40 marks pages 6 and 7 absent. With eight pages and four slots, repeated sweeps over every page force eviction on every pass and wrap the round-robin pointer several times. They also reach both faulting pages. Four slots also make it cheap to lock one slot and then all of them, which reaches the pointer's skip path and the dropped-refill case.

// File: rtl/vat_pkg.sv
package vat_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_ISSUE = 2'd1,
    WALK_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/vat_tlb_store.sv
module vat_tlb_store #(
  parameter int N     = 4,
  parameter int VPN_W = 3,
  parameter int PFN_W = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             wire_en,
  input  logic [IDX_W-1:0] wire_idx,
  input  logic [VPN_W-1:0] wire_vpn,
  input  logic [PFN_W-1:0] wire_pfn,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     wired_vec
);
  logic [VPN_W-1:0] ent_vpn [N];
  logic [PFN_W-1:0] ent_pfn [N];

  // lowest matching slot wins
  always_comb begin
    lk_hit = 1'b0;
    lk_pfn = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_vec[i] && ent_vpn[i] == lk_vpn && !lk_hit) begin
        lk_hit = 1'b1;
        lk_pfn = ent_pfn[i];
      end
    end
  end

  // priority per slot: lock write, then refill, then flush
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_vec <= '0;
      wired_vec <= '0;
      for (int i = 0; i < N; i++) begin
        ent_vpn[i] <= '0;
        ent_pfn[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wire_en && wire_idx == IDX_W'(i)) begin
          valid_vec[i] <= 1'b1;
          wired_vec[i] <= 1'b1;
          ent_vpn[i]   <= wire_vpn;
          ent_pfn[i]   <= wire_pfn;
        end else if (fill_en && fill_idx == IDX_W'(i)) begin
          valid_vec[i] <= 1'b1;
          wired_vec[i] <= 1'b0;
          ent_vpn[i]   <= fill_vpn;
          ent_pfn[i]   <= fill_pfn;
        end else if (flush && !wired_vec[i]) begin
          valid_vec[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/vat_victim_pick.sv
module vat_victim_pick #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     wired_vec,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_ok
);
  logic [IDX_W-1:0] ptr_q;

  // N is a power of two, so slot arithmetic wraps naturally
  function automatic logic [IDX_W-1:0] slot_after(logic [IDX_W-1:0] base, int step);
    return base + IDX_W'(step);
  endfunction

  always_comb begin
    victim_ok  = 1'b0;
    victim_idx = ptr_q;
    for (int k = N - 1; k >= 0; k--) begin
      if (!wired_vec[slot_after(ptr_q, k)]) begin
        victim_ok  = 1'b1;
        victim_idx = slot_after(ptr_q, k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (advance)
      ptr_q <= slot_after(victim_idx, 1);
  end
endmodule

// File: rtl/vat_walk_fsm.sv
module vat_walk_fsm
  import vat_pkg::*;
#(
  parameter int VPN_W = 3,
  parameter int PFN_W = 4,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic [AW-1:0]    pt_base,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PFN_W:0]   mem_rd_data,
  output logic             busy,
  output logic             done,
  output logic             done_fault,
  output logic [PFN_W-1:0] done_pfn,
  output logic [VPN_W-1:0] walk_vpn
);
  walk_state_e      state_q;
  logic [VPN_W-1:0] vpn_q;

  function automatic logic [AW-1:0] entry_addr(logic [AW-1:0] base, logic [VPN_W-1:0] vpn);
    return base + AW'(vpn);
  endfunction

  assign busy        = (state_q != WALK_IDLE);
  assign mem_rd_en   = (state_q == WALK_ISSUE);
  assign mem_rd_addr = entry_addr(pt_base, vpn_q);
  assign done        = (state_q == WALK_WAIT) && mem_rd_valid;
  assign done_fault  = !mem_rd_data[PFN_W];
  assign done_pfn    = mem_rd_data[PFN_W-1:0];
  assign walk_vpn    = vpn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      vpn_q   <= '0;
    end else begin
      unique case (state_q)
        WALK_IDLE: if (start) begin
          state_q <= WALK_ISSUE;
          vpn_q   <= start_vpn;
        end
        WALK_ISSUE: state_q <= WALK_WAIT;
        WALK_WAIT:  if (mem_rd_valid) state_q <= WALK_IDLE;
        default:    state_q <= WALK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vat_translator.sv
module vat_translator #(
  parameter int VA_W  = 14,
  parameter int OFF_W = 11,
  parameter int PFN_W = 4,
  parameter int TLB_N = 4,
  parameter int AW    = 8,
  parameter int CNT_W = 16,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int IDX_W = $clog2(TLB_N),
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic [AW-1:0]    pt_base,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PFN_W:0]   mem_rd_data,
  input  logic             flush,
  input  logic             wire_en,
  input  logic [IDX_W-1:0] wire_slot,
  input  logic [VPN_W-1:0] wire_vpn,
  input  logic [PFN_W-1:0] wire_pfn,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  function automatic logic [VPN_W-1:0] page_of(logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction
  function automatic logic [OFF_W-1:0] offset_of(logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction
  function automatic logic [PA_W-1:0] join_pa(logic [PFN_W-1:0] pfn, logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  // named internal events
  logic             accept, hit_acc, miss_acc;
  logic             lk_hit;
  logic [PFN_W-1:0] lk_pfn;
  logic             walk_busy, walk_done, walk_fault;
  logic [PFN_W-1:0] walk_pfn;
  logic [VPN_W-1:0] walk_vpn;
  logic             fill_en;
  logic [IDX_W-1:0] fill_idx;
  logic             victim_ok;
  logic [TLB_N-1:0] ent_valid, ent_wired;
  logic [OFF_W-1:0] off_q;

  assign req_ready = !walk_busy;
  assign accept    = req_valid && req_ready;
  assign hit_acc   = accept && lk_hit;
  assign miss_acc  = accept && !lk_hit;
  assign fill_en   = walk_done && !walk_fault && victim_ok;

  assign rsp_valid = hit_acc || walk_done;
  assign rsp_hit   = hit_acc;
  assign rsp_fault = walk_done && walk_fault;
  assign rsp_paddr = hit_acc ? join_pa(lk_pfn, offset_of(req_vaddr))
                             : join_pa(walk_pfn, off_q);

  vat_tlb_store #(.N(TLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(page_of(req_vaddr)), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .flush(flush),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(walk_vpn), .fill_pfn(walk_pfn),
    .wire_en(wire_en), .wire_idx(wire_slot), .wire_vpn(wire_vpn), .wire_pfn(wire_pfn),
    .valid_vec(ent_valid), .wired_vec(ent_wired)
  );

  vat_victim_pick #(.N(TLB_N)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .wired_vec(ent_wired), .advance(fill_en),
    .victim_idx(fill_idx), .victim_ok(victim_ok)
  );

  vat_walk_fsm #(.VPN_W(VPN_W), .PFN_W(PFN_W), .AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(miss_acc), .start_vpn(page_of(req_vaddr)), .pt_base(pt_base),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .busy(walk_busy), .done(walk_done), .done_fault(walk_fault),
    .done_pfn(walk_pfn), .walk_vpn(walk_vpn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q      <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (miss_acc) off_q <= offset_of(req_vaddr);
      if (hit_acc)  hit_count  <= hit_count + 1'b1;
      if (miss_acc) miss_count <= miss_count + 1'b1;
    end
  end
endmodule

// File: rtl/vat_translator_chk.sv
module vat_translator_chk #(
  parameter int VA_W  = 14,
  parameter int OFF_W = 11,
  parameter int PFN_W = 4,
  parameter int TLB_N = 4,
  parameter int AW    = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(TLB_N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic [AW-1:0]    pt_base,
  input logic             mem_rd_en,
  input logic [AW-1:0]    mem_rd_addr,
  input logic             mem_rd_valid,
  input logic [PFN_W:0]   mem_rd_data,
  input logic             flush,
  input logic             wire_en,
  input logic [CNT_W-1:0] hit_count,
  input logic             fill_en,
  input logic [IDX_W-1:0] fill_idx,
  input logic [TLB_N-1:0] ent_valid,
  input logic [TLB_N-1:0] ent_wired
);
  a_r1_hit_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (req_valid && req_ready));

  a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  a_r2_stall_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);

  a_r2_read_address: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !rsp_hit) |=>
      (mem_rd_en && mem_rd_addr == $past(pt_base) + AW'($past(req_vaddr[VA_W-1:OFF_W]))));

  a_r4_fault_from_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (mem_rd_valid && !mem_rd_data[PFN_W]));

  a_r4_no_fill_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> !fill_en);

  a_r6_fill_skips_wired: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !ent_wired[fill_idx]);

  a_r6_wired_retained: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ent_valid & ent_wired)) |=>
      ((ent_valid & $past(ent_valid & ent_wired)) == $past(ent_valid & ent_wired)));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wire_en && !fill_en) |=> (ent_valid == $past(ent_valid & ent_wired)));

  a_r10_hit_counter: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |=> (hit_count == $past(hit_count) + 1'b1));
endmodule

bind vat_translator vat_translator_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .TLB_N(TLB_N), .AW(AW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .pt_base(pt_base), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .flush(flush),
  .wire_en(wire_en), .hit_count(hit_count), .fill_en(fill_en), .fill_idx(fill_idx),
  .ent_valid(ent_valid), .ent_wired(ent_wired)
);

// File: tb/tb_vat_translator.sv
module tb_vat_translator;
  localparam int VA_W = 14, OFF_W = 11, PFN_W = 4, TLB_N = 4, AW = 8, CNT_W = 16;
  localparam int VPN_W = VA_W - OFF_W, IDX_W = 2, PA_W = PFN_W + OFF_W;
  localparam logic [AW-1:0] BASE = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault;
  logic [PA_W-1:0] rsp_paddr;
  logic [AW-1:0] pt_base = BASE;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic mem_rd_valid = 1'b0;
  logic [PFN_W:0] mem_rd_data = '0;
  logic flush = 1'b0, wire_en = 1'b0;
  logic [IDX_W-1:0] wire_slot = '0;
  logic [VPN_W-1:0] wire_vpn = '0;
  logic [PFN_W-1:0] wire_pfn = '0;
  logic [CNT_W-1:0] hit_count, miss_count;

  always #2 clk = ~clk;

  vat_translator dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  int reads = 0, exp_hits = 0, exp_miss = 0;
  logic [AW-1:0] last_addr = '0;
  int mem_cnt = 0;

  // reference cache model
  logic [VPN_W-1:0] r_vpn [TLB_N];
  logic [PFN_W-1:0] r_pfn [TLB_N];
  bit r_val [TLB_N];
  bit r_wir [TLB_N];
  int r_ptr = 0;

  // table contents: pages 0..5 present with frame page+5, pages 6 and 7 absent
  function automatic logic [PFN_W:0] pte_at(logic [AW-1:0] a);
    int v = int'(a) - int'(BASE);
    if (v >= 0 && v < 6) return {1'b1, PFN_W'(v + 5)};
    return {1'b0, PFN_W'(0)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // table memory: answers two cycles after the read strobe
  always @(negedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_en && mem_cnt == 0) begin
      reads++;
      last_addr = mem_rd_addr;
      mem_cnt = 2;
    end else if (mem_cnt > 0) begin
      mem_cnt--;
      if (mem_cnt == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= pte_at(last_addr);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int ref_find(logic [VPN_W-1:0] v);
    for (int i = 0; i < TLB_N; i++)
      if (r_val[i] && r_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic translate(int page, int off);
    logic [VPN_W-1:0] v = VPN_W'(page);
    int idx = ref_find(v);
    int rd0 = reads;
    logic [PFN_W:0] pte;
    int wait_n = 0;
    req_vaddr = {v, OFF_W'(off)};
    req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
    if (idx >= 0) begin
      exp_hits++;
      chk(rsp_valid && rsp_hit, "R1 hit in acceptance cycle", int'({rsp_valid, rsp_hit}), 3);
      chk(rsp_paddr == {r_pfn[idx], OFF_W'(off)}, "R1 hit address",
          int'(rsp_paddr), int'({r_pfn[idx], OFF_W'(off)}));
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      chk(reads == rd0, "R1 no table read on hit", reads - rd0, 0);
    end else begin
      exp_miss++;
      chk(!rsp_valid, "R1 no response in miss cycle", int'(rsp_valid), 0);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(!req_ready, "R2 stalled during walk", int'(req_ready), 0);
      while (!rsp_valid && wait_n < 20) begin
        @(negedge clk); #1; wait_n++;
      end
      pte = pte_at(BASE + AW'(v));
      chk(reads == rd0 + 1, "R2 exactly one read", reads - rd0, 1);
      chk(last_addr == BASE + AW'(v), "R2 read address", int'(last_addr), int'(BASE + AW'(v)));
      chk(rsp_valid && !rsp_hit, "R3 walk response", int'({rsp_valid, rsp_hit}), 2);
      if (pte[PFN_W]) begin
        chk(!rsp_fault, "R3 present entry no fault", int'(rsp_fault), 0);
        chk(rsp_paddr == {pte[PFN_W-1:0], OFF_W'(off)}, "R3 walked address",
            int'(rsp_paddr), int'({pte[PFN_W-1:0], OFF_W'(off)}));
      end else begin
        chk(rsp_fault, "R4 absent entry faults", int'(rsp_fault), 1);
      end
      @(posedge clk);
      if (pte[PFN_W]) begin
        int vic = -1;
        for (int k = 0; k < TLB_N; k++)
          if (vic < 0 && !r_wir[(r_ptr + k) % TLB_N]) vic = (r_ptr + k) % TLB_N;
        if (vic >= 0) begin
          r_val[vic] = 1; r_vpn[vic] = v; r_pfn[vic] = pte[PFN_W-1:0];
          r_ptr = (vic + 1) % TLB_N;
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < TLB_N; i++) if (!r_wir[i]) r_val[i] = 0;
  endtask

  task automatic do_wire(int slot, int page, int frame);
    wire_en = 1'b1; wire_slot = IDX_W'(slot);
    wire_vpn = VPN_W'(page); wire_pfn = PFN_W'(frame);
    @(posedge clk); @(negedge clk);
    wire_en = 1'b0;
    r_val[slot] = 1; r_wir[slot] = 1;
    r_vpn[slot] = VPN_W'(page); r_pfn[slot] = PFN_W'(frame);
  endtask

  task automatic sweep(bit up, int seed);
    for (int p = 0; p < 8; p++) begin
      int pg = up ? p : 7 - p;
      translate(pg, (pg * 291 + seed) % 2048);
    end
  endtask

  initial begin
    for (int i = 0; i < TLB_N; i++) begin
      r_val[i] = 0; r_wir[i] = 0; r_vpn[i] = '0; r_pfn[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R11 ready in reset", int'(req_ready), 1);
    chk(!rsp_valid && !mem_rd_en, "R11 idle in reset", int'({rsp_valid, mem_rd_en}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(hit_count == 0 && miss_count == 0, "R10 counters reset", int'(hit_count + miss_count), 0);
    @(negedge clk);

    // miss on every page, then eviction patterns in both directions
    sweep(1'b1, 0);
    sweep(1'b1, 2047);
    sweep(1'b0, 5);
    translate(5, 17); translate(5, 18);   // R3 refill then hit
    translate(6, 1);  translate(6, 2);    // R4 repeated fault
    translate(2, 0);  translate(3, 0); translate(4, 0); translate(0, 0); translate(1, 0);  // R5 order

    // R8 flush with nothing locked
    do_flush();
    translate(5, 100);
    translate(5, 101);

    // R9 lock a page the table calls absent; R8 and R6 keep it
    do_wire(1, 7, 3);
    translate(7, 42);
    do_flush();
    translate(7, 43);
    sweep(1'b1, 9);
    sweep(1'b0, 77);
    translate(7, 2047);

    // R7 all slots locked
    do_flush();
    do_wire(0, 6, 1);
    do_wire(2, 4, 14);
    do_wire(3, 2, 13);
    translate(6, 300);
    translate(0, 301);
    translate(0, 302);
    translate(4, 5);

    #1;
    chk(hit_count == CNT_W'(exp_hits), "R10 hit count", int'(hit_count), exp_hits);
    chk(miss_count == CNT_W'(exp_miss), "R10 miss count", int'(miss_count), exp_miss);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule